// File: doc/BRIEF.md
# PRBS-11 Bit Error Rate Tester

This block checks a stream of received, already decoded bits against a locally generated PRBS-11 reference. The received bits arrive one per cycle at most, qualified by a valid strobe. Idle cycles carry no data. The tester searches the incoming stream for the start of the pseudo-random sequence with a correlating start detector. When the start is found, it seeds its own generator at that point. It then confirms the alignment over a short run of correctly predicted bits before it declares sync.

Once synchronized, the reference generator runs on its own and compares every valid bit with its prediction. Mismatches are counted over consecutive windows of 10,000 valid bits. The total of each window is latched and shown until the next window closes. A one-cycle pulse marks every 8-bit group that held at least one mismatch. A window with too many errors means the alignment has been lost, so the tester drops sync and searches again. The usual use is a link test in which the far end transmits the PRBS-11 pattern and the host reads the sync flag and the window count.

Top module: `bert_prbs11`

## Requirements
- R1: While reset is asserted and in the cycle after reset is released, `sync_o` is 0, `err_count_o` is 0 and `byte_err_o` is 0.
- R2: The reference follows x^11+x^9+1: each bit equals the XOR of the bits 11 and 9 positions earlier in the valid-bit stream. The sequence start is the point where 11 consecutive ones have just been received. An error-free stream that follows this rule yields a window count of 0.
- R3: A start is recognised on the valid bit that makes at least MATCH_MIN (default 11) of the last 11 received bits agree with eleven ones. `sync_o` rises on the clock edge that samples the CONFIRM_LEN-th (default 16) following bit, provided every one of those bits matched the prediction. A mismatch during that confirmation returns the tester to searching, and `sync_o` stays 0.
- R4: While synchronized, the reference generator advances from its own predictions and never reloads from received bits, so one corrupted bit counts as exactly one error.
- R5: Once sync is declared, valid bits are grouped into consecutive windows of WIN_LEN (default 10,000). On the edge that samples the last bit of a window, `err_count_o` takes the number of mismatches in that window, including that last bit.
- R6: `err_count_o` holds its latched value until the next window completes, including through loss of sync and renewed acquisition.
- R7: From the moment sync is declared, valid bits form consecutive groups of 8. In the cycle after the edge that samples the 8th bit of a group, `byte_err_o` is 1 for exactly one cycle if any bit of that group mismatched, and is 0 otherwise.
- R8: When a completed window holds more than DROP_LIM (default 2,500) errors, `sync_o` falls on that same edge, after the count is latched, and the tester searches again. A window with exactly DROP_LIM errors keeps sync.
- R9: A cycle with `rx_vld` low has no effect: it neither advances the reference, the window nor the byte grouping. `byte_err_o` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received decoded bit |
| rx_vld | input | 1 | Qualifies `rx_bit` in this cycle |
| sync_o | output | 1 | 1 while locked to the received sequence |
| err_count_o | output | 14 | Error count of the last completed window |
| byte_err_o | output | 1 | One-cycle pulse for an 8-bit group with an error |

## Verification
The hardest state to reach from the ports is the window-end decision at the loss-of-sync boundary. It needs a fully acquired tester followed by a full window with exactly 2,500 errors, and then another with exactly 2,501. The stimulus first acquires lock by sending a start run behind filler data that can never contain eleven ones in a row. It then drives windows in which every fourth bit is flipped, plus one extra flip in the second window, so the count lands exactly on each side of the limit. Random error injection mixed with idle gaps, and a deliberately broken confirmation, cover the ordinary paths around it.

// File: rtl/bert_pkg.sv
package bert_pkg;

    localparam int PRBS_W   = 11;
    localparam int PRBS_TAP = 9;
    localparam logic [PRBS_W-1:0] PRBS_START = '1;

    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCKED  = 2'd2
    } bert_state_e;

    // Bit 0 holds the newest bit; the prediction combines the bits
    // PRBS_W and PRBS_TAP positions back.
    function automatic logic prbs_predict(input logic [PRBS_W-1:0] hist);
        return hist[PRBS_W-1] ^ hist[PRBS_TAP-1];
    endfunction

endpackage

// File: rtl/bert_start_corr.sv
module bert_start_corr import bert_pkg::*; #(
    parameter int MATCH_MIN = PRBS_W,
    localparam int SUM_W    = $clog2(PRBS_W + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic vld_i,
    output logic hit_o
);

    typedef struct packed {
        logic [PRBS_W-1:0] hist;
    } corr_t;

    corr_t q, d;
    logic [PRBS_W-1:0] win;
    logic [PRBS_W-1:0] agree;
    logic [SUM_W-1:0]  score;

    assign win = {q.hist[PRBS_W-2:0], bit_i};

    for (genvar k = 0; k < PRBS_W; k++) begin : g_agree
        assign agree[k] = ~(win[k] ^ PRBS_START[k]);
    end

    always_comb begin
        d     = q;
        score = '0;
        for (int k = 0; k < PRBS_W; k++) begin
            score = score + SUM_W'(agree[k]);
        end
        if (vld_i) begin
            d.hist = win;
        end
        hit_o = vld_i && (score >= SUM_W'(MATCH_MIN));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.hist <= '0;
        end else begin
            q <= d;
        end
    end

    AST_FULL_MATCH_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && MATCH_MIN == PRBS_W) |-> (win == PRBS_START)); // R3

endmodule

// File: rtl/bert_err_window.sv
module bert_err_window #(
    parameter int WIN_LEN   = 10000,
    parameter int DROP_LIM  = 2500,
    parameter int BYTE_LEN  = 8,
    localparam int CNT_W    = $clog2(WIN_LEN + 1),
    localparam int POS_W    = $clog2(WIN_LEN),
    localparam int BPOS_W   = $clog2(BYTE_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic             err_i,
    output logic [CNT_W-1:0] count_o,
    output logic             win_bad_o,
    output logic             byte_err_o
);

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [CNT_W-1:0]  acc;
        logic [CNT_W-1:0]  latched;
        logic [BPOS_W-1:0] bpos;
        logic              bflag;
        logic              bpulse;
    } win_t;

    win_t q, d;
    logic [CNT_W-1:0] total;
    logic             win_end;
    logic             byte_end;

    always_comb begin
        d        = q;
        d.bpulse = 1'b0;
        total    = q.acc + CNT_W'(err_i);
        win_end  = en_i && (q.pos == POS_W'(WIN_LEN - 1));
        byte_end = en_i && (q.bpos == BPOS_W'(BYTE_LEN - 1));
        if (clr_i) begin
            d.pos   = '0;
            d.acc   = '0;
            d.bpos  = '0;
            d.bflag = 1'b0;
        end else if (en_i) begin
            if (win_end) begin
                d.pos     = '0;
                d.acc     = '0;
                d.latched = total;
            end else begin
                d.pos = q.pos + POS_W'(1);
                d.acc = total;
            end
            if (byte_end) begin
                d.bpos   = '0;
                d.bflag  = 1'b0;
                d.bpulse = q.bflag | err_i;
            end else begin
                d.bpos  = q.bpos + BPOS_W'(1);
                d.bflag = q.bflag | err_i;
            end
        end
        win_bad_o = win_end && !clr_i && (total > CNT_W'(DROP_LIM));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign count_o    = q.latched;
    assign byte_err_o = q.bpulse;

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(q.latched)); // R6
    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        q.latched <= CNT_W'(WIN_LEN)); // R5
    AST_BYTE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.bpulse |=> !q.bpulse); // R7
    AST_IDLE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> ($stable(q.acc) && $stable(q.pos) && $stable(q.bpos))); // R9

endmodule

// File: rtl/bert_prbs11.sv
module bert_prbs11 import bert_pkg::*; #(
    parameter int WIN_LEN     = 10000,
    parameter int DROP_LIM    = 2500,
    parameter int MATCH_MIN   = PRBS_W,
    parameter int CONFIRM_LEN = 16,
    parameter int BYTE_LEN    = 8,
    localparam int CNT_W      = $clog2(WIN_LEN + 1),
    localparam int CONF_W     = $clog2(CONFIRM_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_vld,
    output logic             sync_o,
    output logic [CNT_W-1:0] err_count_o,
    output logic             byte_err_o
);

    typedef struct packed {
        bert_state_e       st;
        logic [PRBS_W-1:0] ref_r;
        logic [CONF_W-1:0] conf;
    } ctrl_t;

    ctrl_t q, d;
    logic  exp_bit;
    logic  mism;
    logic  hit;
    logic  win_bad;
    logic  win_clr;
    logic  win_en;

    assign exp_bit = prbs_predict(q.ref_r);
    assign mism    = rx_bit ^ exp_bit;
    assign win_clr = (q.st != ST_LOCKED);
    assign win_en  = rx_vld && (q.st == ST_LOCKED);

    bert_start_corr #(
        .MATCH_MIN (MATCH_MIN)
    ) i_corr (
        .clk   (clk),
        .rst_n (rst_n),
        .bit_i (rx_bit),
        .vld_i (rx_vld),
        .hit_o (hit)
    );

    bert_err_window #(
        .WIN_LEN  (WIN_LEN),
        .DROP_LIM (DROP_LIM),
        .BYTE_LEN (BYTE_LEN)
    ) i_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (win_clr),
        .en_i       (win_en),
        .err_i      (mism),
        .count_o    (err_count_o),
        .win_bad_o  (win_bad),
        .byte_err_o (byte_err_o)
    );

    always_comb begin
        d = q;
        case (q.st)
            ST_SEARCH: begin
                if (hit) begin
                    d.ref_r = PRBS_START;
                    d.conf  = '0;
                    d.st    = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (rx_vld) begin
                    d.ref_r = {q.ref_r[PRBS_W-2:0], exp_bit};
                    if (mism) begin
                        d.st = ST_SEARCH;
                    end else if (q.conf == CONF_W'(CONFIRM_LEN - 1)) begin
                        d.st = ST_LOCKED;
                    end else begin
                        d.conf = q.conf + CONF_W'(1);
                    end
                end
            end
            ST_LOCKED: begin
                if (rx_vld) begin
                    d.ref_r = {q.ref_r[PRBS_W-2:0], exp_bit};
                    if (win_bad) begin
                        d.st = ST_SEARCH;
                    end
                end
            end
            default: d.st = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_SEARCH;
            q.ref_r <= '0;
            q.conf  <= '0;
        end else begin
            q <= d;
        end
    end

    assign sync_o = (q.st == ST_LOCKED);

    AST_LOCK_FROM_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && !$past(sync_o)) |-> ($past(q.st) == ST_CONFIRM && $past(rx_vld))); // R3
    AST_REF_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_SEARCH) |-> (q.ref_r != '0)); // R2
    AST_DROP_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_o && win_bad) |=> !sync_o); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_vld |=> ($stable(q.ref_r) && q.st == $past(q.st))); // R9

endmodule

// File: tb/test_bert_prbs11.sv
module test_bert_prbs11;

    localparam int WIN  = 10000;
    localparam int CONF = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_bit;
    logic        rx_vld;
    logic        sync_o;
    logic [13:0] err_count_o;
    logic        byte_err_o;

    int          total = 0;
    int          bad = 0;
    logic [10:0] g = '0;
    logic        exp_sync = 1'b0;
    int          latched_model = 0;
    int          seed_sink;

    always #4 clk = ~clk;

    bert_prbs11 i_bert_prbs11 (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_bit      (rx_bit),
        .rx_vld      (rx_vld),
        .sync_o      (sync_o),
        .err_count_o (err_count_o),
        .byte_err_o  (byte_err_o)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic tick(input logic b, input logic v);
        rx_bit = b;
        rx_vld = v;
        @(negedge clk);
    endtask

    task automatic idle_gap();
        tick(1'($urandom % 2), 1'b0);
        chk("R9 byte_err after idle cycle", int'(byte_err_o), 0);
        chk("R9 sync after idle cycle", int'(sync_o), int'(exp_sync));
    endtask

    task automatic prbs_bit(input logic flip);
        logic nb;
        nb = g[10] ^ g[8];
        g  = {g[9:0], nb};
        tick(nb ^ flip, 1'b1);
    endtask

    task automatic send_junk(input int n);
        for (int i = 0; i < n; i++) begin
            logic jb;
            jb = (i % 6 == 0 || i == n - 1) ? 1'b0 : 1'($urandom % 2);
            tick(jb, 1'b1);
        end
    endtask

    task automatic send_start();
        for (int i = 0; i < 11; i++) begin
            tick(1'b1, 1'b1);
        end
        g = '1;
    endtask

    task automatic acquire();
        send_junk(30);
        chk("R3 no sync while searching", int'(sync_o), 0);
        send_start();
        for (int k = 0; k < CONF - 1; k++) begin
            prbs_bit(1'b0);
        end
        chk("R3 no sync one bit before confirmation ends", int'(sync_o), 0);
        prbs_bit(1'b0);
        chk("R3 sync after confirmation", int'(sync_o), 1);
        exp_sync = 1'b1;
    endtask

    task automatic run_window(input int mode, input logic gaps, input logic sync_after);
        int   errs;
        int   prev;
        logic bflag;
        errs  = 0;
        prev  = latched_model;
        bflag = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            logic e;
            if (gaps && ($urandom % 5 == 0)) idle_gap();
            case (mode)
                0:       e = ($urandom % 64 == 0);
                1:       e = (i % 4 == 3);
                2:       e = (i % 4 == 3) || (i == 0);
                default: e = 1'b0;
            endcase
            prbs_bit(e);
            errs += int'(e);
            bflag = bflag | e;
            if (i % 8 == 7) begin
                chk("R7 byte error pulse at group end", int'(byte_err_o), int'(bflag));
                bflag = 1'b0;
            end else begin
                chk("R7 no byte error pulse inside group", int'(byte_err_o), 0);
            end
            if (i == 0) chk("R6 count held into next window", int'(err_count_o), prev);
            if (i == WIN / 2) chk("R4 sync kept mid-window", int'(sync_o), 1);
        end
        chk("R5 latched window error count", int'(err_count_o), errs);
        chk("R8 sync after window end", int'(sync_o), int'(sync_after));
        latched_model = errs;
        exp_sync = sync_after;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        seed_sink = $urandom(5);
        rst_n  = 1'b0;
        rx_bit = 1'b0;
        rx_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 sync in reset", int'(sync_o), 0);
        chk("R1 count in reset", int'(err_count_o), 0);
        chk("R1 byte_err in reset", int'(byte_err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sync after reset", int'(sync_o), 0);
        chk("R1 count after reset", int'(err_count_o), 0);

        // Random errors with idle gaps: each flipped bit counted once
        acquire();
        run_window(0, 1'b1, 1'b1);
        // Exactly at the limit: sync stays
        run_window(1, 1'b0, 1'b1);
        // One over the limit: sync drops after latching
        run_window(2, 1'b0, 1'b0);
        chk("R8 count at drop window", int'(err_count_o), 2501);

        send_junk(40);
        chk("R6 count held after sync loss", int'(err_count_o), 2501);
        chk("R8 stays unsynced on filler", int'(sync_o), 0);

        // Broken confirmation returns to search
        send_junk(30);
        send_start();
        for (int k = 0; k < 6; k++) prbs_bit(1'b0);
        prbs_bit(1'b1);
        for (int k = 0; k < 20; k++) prbs_bit(1'b0);
        chk("R3 confirmation mismatch restarts search", int'(sync_o), 0);

        // Clean stream after renewed acquisition gives zero errors
        acquire();
        run_window(3, 1'b1, 1'b1);
        chk("R2 clean sequence gives zero count", int'(err_count_o), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule